// File: doc/BRIEF.md
# Manchester receive decoder with carrier sense

This block turns a Manchester-coded serial bit stream into NRZ data, a recovered bit clock and a carrier-sense flag. The line arrives as one logic-level signal, already converted from the differential pair. A fast sample clock oversamples it at `SPB` samples per bit cell, which is 8 by default, so an 80 MHz sample clock serves a 10 Mb/s line. A second input carries the local transmit encoder output. When the loopback select is high, the decoder listens to that signal and ignores the line.

Each sample passes through a short synchronizer, and a change of level is flagged as a transition. A three-state machine decides which transitions are mid-bit transitions, which carry the data, and which are cell-boundary transitions, which do not.

- `ST_IDLE`: the line is quiet and the recovered clock is held low. On any transition it moves to `ST_LOCK`, acquiring that transition as a mid-bit.
- `ST_LOCK`: carrier sense is high. A transition that arrives early enough after the previous mid-bit is a boundary and is ignored. A later one is accepted as the next mid-bit, and the state stays `ST_LOCK`. When 1.5 bit times pass with nothing accepted, it moves to `ST_FADE`.
- `ST_FADE`: carrier sense is low but the recovered clock keeps running. A transition re-acquires and returns to `ST_LOCK`. Five bit times of silence since the last mid-bit move it to `ST_IDLE`.

A phase counter is cleared on every accepted mid-bit and then counts around one bit cell. It produces a 50 % duty recovered clock that rises half a cell after the data output changes, so a controller can sample the data on the rising clock edge.

Top module: `mrx_decoder`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, that edge clears `carrier_sense`, `rcv_clk` and `rcv_data` to 0 and returns the machine to `ST_IDLE`.
- R2: The selected input reaches the decoder through two sample-clock registers. A level change captured at edge E is acted on at edge E+2, and no output reacts at edge E+1.
- R3: While not in `ST_LOCK`, the first transition is accepted as a mid-bit, and `carrier_sense` rises at the same edge that accepts it.
- R4: A bit cell carries the complement of the bit in its first half and the bit itself in its second half. An accepted rising (0 to 1) transition therefore decodes as 1 and an accepted falling transition as 0. `rcv_data` takes the decoded value at the accepting edge and holds it until the next accepted mid-bit.
- R5: In `ST_LOCK`, a transition that falls fewer than `SPB - SPB/4` samples (6) after the last accepted mid-bit is ignored. One at 6 samples or more is accepted, which covers mid-bit spacings of 6 to 10 samples.
- R6: `rcv_clk` is low for the first `SPB/2` samples after an accepted mid-bit and high for the rest of the cell. It rises 4 samples after the accepting edge, and `rcv_data` never changes at a rising edge of `rcv_clk`.
- R7: `carrier_sense` falls exactly 12 samples (1.5 bit times) after the last accepted mid-bit. A transition accepted at exactly 12 samples keeps it high without a gap, and one at 13 samples lets it drop for one sample.
- R8: After `carrier_sense` falls, `rcv_clk` keeps its phase until 40 samples (5 bit times) after the last accepted mid-bit. From then on it is held low until a new transition is accepted.
- R9: With `loop_en` high, `loop_in` is decoded and activity on `line_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, `SPB` samples per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Manchester line input at logic level |
| loop_in | input | 1 | Local transmit encoder output, used in loopback |
| loop_en | input | 1 | High selects `loop_in` in place of `line_in` |
| rcv_clk | output | 1 | Recovered bit clock, held low when idle |
| rcv_data | output | 1 | Decoded NRZ data, valid at rising `rcv_clk` |
| carrier_sense | output | 1 | High while valid Manchester data is being received |

## Verification
Two functions can fall in the same sample: the carrier-sense timeout and the acceptance of a transition. The bench provokes this by placing the mid-bit that follows a frame's last bit exactly 12 samples after it, and then 13 samples after it. At 12 samples the accepted transition must win, so carrier sense shows only the single final fall for the whole frame. At 13 samples carrier sense must drop once in between and rise again, while both bits still appear at rising recovered-clock edges with carrier high. A second run places a stretched cell of 10 samples, a shortened cell of 6 samples and a one-sample glitch within a few samples of one another, to judge the acceptance window against the boundary rule.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
package mrx_pkg;

    // Receive tracking state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // quiet line, recovered clock gated low
        ST_LOCK = 2'd1,   // tracking mid-bits, carrier sense high
        ST_FADE = 2'd2    // carrier dropped, clock still running
    } mrx_state_e;

endpackage

// File: rtl/mrx_input_sel.sv
`timescale 1ns/1ps
module mrx_input_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic loop_in,
    input  logic loop_en,
    output logic edge_seen,
    output logic level
);

    localparam int LAST = SYNC_STAGES - 1;

    logic             sel;
    logic [LAST:0]    sync_q;
    logic             prev_q;

    // Loopback select ahead of the synchronizer
    assign sel = loop_en ? loop_in : line_in;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= sel;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign edge_seen = sync_q[LAST] ^ prev_q;
    assign level     = sync_q[LAST];

endmodule

// File: rtl/mrx_phase.sv
`timescale 1ns/1ps
module mrx_phase #(
    parameter int SPB = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic run_next,
    output logic rcv_clk
);

    localparam int PW   = (SPB > 2) ? $clog2(SPB) : 1;
    localparam int HALF = SPB / 2;

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_n;

    // Phase restarts on each accepted mid-bit, otherwise wraps each cell
    always_comb begin
        if (accept)                    ph_n = '0;
        else if (ph_q == PW'(SPB - 1)) ph_n = '0;
        else                           ph_n = ph_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= '0;
            rcv_clk <= 1'b0;
        end else begin
            ph_q    <= ph_n;
            rcv_clk <= run_next && (ph_n >= PW'(HALF));
        end
    end

endmodule

// File: rtl/mrx_track.sv
`timescale 1ns/1ps
module mrx_track
    import mrx_pkg::*;
#(
    parameter int MIN_GAP   = 6,
    parameter int CRS_HOLD  = 12,
    parameter int IDLE_HOLD = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       edge_seen,
    input  logic       level,
    output logic       accept,
    output logic       run_next,
    output logic       carrier_sense,
    output logic       rcv_data,
    output mrx_state_e fsm_state
);

    localparam int CW = $clog2(IDLE_HOLD + 1);

    mrx_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW:0]   elapsed;

    // Next state and acceptance decision
    always_comb begin
        elapsed = {1'b0, cnt_q} + (CW+1)'(1);
        state_n = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_seen) begin
                    accept  = 1'b1;
                    state_n = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (edge_seen && (elapsed >= (CW+1)'(MIN_GAP))) begin
                    accept  = 1'b1;
                    state_n = ST_LOCK;
                end else if (elapsed == (CW+1)'(CRS_HOLD)) begin
                    state_n = ST_FADE;
                end
            end
            ST_FADE: begin
                if (edge_seen) begin
                    accept  = 1'b1;
                    state_n = ST_LOCK;
                end else if (elapsed == (CW+1)'(IDLE_HOLD)) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase

        if (accept)                       cnt_n = '0;
        else if (cnt_q != CW'(IDLE_HOLD)) cnt_n = cnt_q + CW'(1);
        else                              cnt_n = cnt_q;

        run_next = (state_n != ST_IDLE);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            carrier_sense <= 1'b0;
            rcv_data      <= 1'b0;
        end else begin
            carrier_sense <= (state_n == ST_LOCK);
            if (accept) rcv_data <= level;
        end
    end

    assign fsm_state = state_q;

endmodule

// File: rtl/mrx_decoder.sv
`timescale 1ns/1ps
module mrx_decoder
    import mrx_pkg::*;
#(
    parameter int SPB         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic loop_in,
    input  logic loop_en,
    output logic rcv_clk,
    output logic rcv_data,
    output logic carrier_sense
);

    localparam int MIN_GAP   = SPB - SPB / 4;
    localparam int CRS_HOLD  = SPB + SPB / 2;
    localparam int IDLE_HOLD = 5 * SPB;

    logic       edge_seen;
    logic       level;
    logic       accept;
    logic       run_next;
    mrx_state_e fsm_state;

    mrx_input_sel #(.SYNC_STAGES(SYNC_STAGES)) u_in (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .loop_in   (loop_in),
        .loop_en   (loop_en),
        .edge_seen (edge_seen),
        .level     (level)
    );

    mrx_track #(
        .MIN_GAP   (MIN_GAP),
        .CRS_HOLD  (CRS_HOLD),
        .IDLE_HOLD (IDLE_HOLD)
    ) u_track (
        .clk           (clk),
        .rst           (rst),
        .edge_seen     (edge_seen),
        .level         (level),
        .accept        (accept),
        .run_next      (run_next),
        .carrier_sense (carrier_sense),
        .rcv_data      (rcv_data),
        .fsm_state     (fsm_state)
    );

    mrx_phase #(.SPB(SPB)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .run_next (run_next),
        .rcv_clk  (rcv_clk)
    );

endmodule

// File: rtl/mrx_decoder_chk.sv
`timescale 1ns/1ps
module mrx_decoder_chk
    import mrx_pkg::*;
#(
    parameter int MIN_GAP   = 6,
    parameter int CRS_HOLD  = 12,
    parameter int IDLE_HOLD = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       edge_seen,
    input logic       accept,
    input mrx_state_e fsm_state,
    input logic       rcv_clk,
    input logic       rcv_data,
    input logic       carrier_sense
);

    localparam int GW = $clog2(IDLE_HOLD + 2);

    // Samples since the last accepted mid-bit, kept by the checker
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                             gap_q <= '0;
        else if (accept)                     gap_q <= '0;
        else if (gap_q != GW'(IDLE_HOLD + 1)) gap_q <= gap_q + GW'(1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!carrier_sense && !rcv_clk && !rcv_data)); // R1

    AST_CRS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(carrier_sense) |-> $past(edge_seen)); // R3

    AST_DATA_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !$stable(rcv_data) |-> $past(accept)); // R4

    AST_NO_SHORT_MIDBIT: assert property (@(posedge clk) disable iff (rst)
        (accept && fsm_state == ST_LOCK) |-> (int'(gap_q) + 1 >= MIN_GAP)); // R5

    AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rcv_clk) |-> $stable(rcv_data)); // R6

    AST_CRS_HOLD_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(carrier_sense) |-> (gap_q == GW'(CRS_HOLD))); // R7

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE) |-> !rcv_clk); // R8

    AST_IDLE_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE && $past(fsm_state) != ST_IDLE) |-> (gap_q == GW'(IDLE_HOLD))); // R8

endmodule

bind mrx_decoder mrx_decoder_chk #(
    .MIN_GAP   (MIN_GAP),
    .CRS_HOLD  (CRS_HOLD),
    .IDLE_HOLD (IDLE_HOLD)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .edge_seen     (edge_seen),
    .accept        (accept),
    .fsm_state     (fsm_state),
    .rcv_clk       (rcv_clk),
    .rcv_data      (rcv_data),
    .carrier_sense (carrier_sense)
);

// File: tb/tb_mrx_decoder.sv
`timescale 1ns/1ps
module tb_mrx_decoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic loop_in = 1'b0;
    logic loop_en = 1'b0;
    logic rcv_clk, rcv_data, carrier_sense;

    mrx_decoder dut (
        .clk           (clk),
        .rst           (rst),
        .line_in       (line_in),
        .loop_in       (loop_in),
        .loop_en       (loop_en),
        .rcv_clk       (rcv_clk),
        .rcv_data      (rcv_data),
        .carrier_sense (carrier_sense)
    );

    always #2.5 clk = ~clk;

    int   n_chk = 0;
    int   n_bad = 0;
    logic done  = 1'b0;

    // Monitor state
    logic mon_on   = 1'b0;
    logic rxc_prev = 1'b0;
    logic crs_prev = 1'b0;
    int   cap_n    = 0;
    int   crs_falls = 0;
    logic cap_bits [64];
    logic exp_bits [64];
    int   exp_n    = 0;
    logic lvl      = 1'b0;
    logic [15:0] lf = 16'hACE1;

    // Frame fields: [38] loopback, [37:32] length, [31:0] bits, LSB first
    localparam int NV = 8;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 6'd8,  32'h0000_00FF},
        {1'b0, 6'd8,  32'h0000_0000},
        {1'b0, 6'd16, 32'h0000_AAAA},
        {1'b0, 6'd16, 32'h0000_5555},
        {1'b1, 6'd32, 32'hDEAD_BEEF},
        {1'b1, 6'd24, 32'h000F_0F0F},
        {1'b0, 6'd1,  32'h0000_0001},
        {1'b0, 6'd32, 32'h1234_5678}
    };

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (rcv_clk && !rxc_prev && carrier_sense && cap_n < 64) begin
                cap_bits[cap_n] = rcv_data;
                cap_n++;
            end
            if (crs_prev && !carrier_sense) crs_falls++;
        end
        rxc_prev = rcv_clk;
        crs_prev = carrier_sense;
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_sample(input logic v);
        @(negedge clk);
        if (loop_en) begin
            loop_in = v;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            line_in = lf[0];
        end else begin
            line_in = v;
        end
        lvl = v;
    endtask

    task automatic send_cell(input logic b, input int h1, input int h2, input int glitch);
        for (int i = 0; i < h1; i++) put_sample(~b);
        for (int i = 0; i < h2; i++) put_sample((i == glitch) ? ~b : b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    task automatic begin_rx();
        cap_n     = 0;
        exp_n     = 0;
        crs_falls = 0;
        mon_on    = 1'b1;
    endtask

    task automatic finish_rx(input string req);
        int bad;
        mon_on = 1'b0;
        check(cap_n == exp_n, req, cap_n, exp_n);
        bad = 0;
        for (int i = 0; i < exp_n; i++) if (cap_bits[i] !== exp_bits[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset state (R1)
        wait_neg(3);
        check(!carrier_sense && !rcv_clk && !rcv_data, "R1 reset outputs", carrier_sense, 0);
        rst = 1'b0;
        wait_neg(5);

        // Pipeline and timing from one rising mid-bit, idle level 0
        @(negedge clk);
        line_in = 1'b1;
        lvl     = 1'b1;
        wait_neg(2);
        check(carrier_sense == 1'b0, "R2 no reaction one edge after capture", carrier_sense, 0);
        wait_neg(1);
        check(carrier_sense == 1'b1, "R3 carrier on first transition", carrier_sense, 1);
        check(rcv_data == 1'b1, "R4 rising mid-bit decodes 1", rcv_data, 1);
        wait_neg(3);
        check(rcv_clk == 1'b0, "R6 clock low before half cell", rcv_clk, 0);
        wait_neg(1);
        check(rcv_clk == 1'b1, "R6 clock rises at half cell", rcv_clk, 1);
        wait_neg(7);
        check(carrier_sense == 1'b1, "R7 carrier held at 11 samples", carrier_sense, 1);
        wait_neg(1);
        check(carrier_sense == 1'b0, "R7 carrier drops at 12 samples", carrier_sense, 0);
        wait_neg(24);
        check(rcv_clk == 1'b1, "R8 clock still running at 36 samples", rcv_clk, 1);
        wait_neg(8);
        check(rcv_clk == 1'b0, "R8 clock held low after 40 samples", rcv_clk, 0);
        wait_neg(20);

        // Vector table of frames
        for (int v = 0; v < NV; v++) begin
            logic        mode;
            int          len;
            logic [31:0] dat;
            logic        b;
            mode = VEC[v][38];
            len  = int'(VEC[v][37:32]);
            dat  = VEC[v][31:0];
            @(negedge clk);
            line_in = lvl;
            loop_in = lvl;
            loop_en = mode;
            wait_neg(4);
            begin_rx();
            for (int i = 0; i < len; i++) begin
                b = dat[i];
                if (i == 0) b = ~lvl;
                send_cell(b, 4, 4, -1);
            end
            wait_neg(60);
            finish_rx(mode ? "R9 loopback frame" : "R4 R6 frame data");
            check(carrier_sense == 1'b0, "R7 carrier low after frame", carrier_sense, 0);
            check(rcv_clk == 1'b0, "R8 clock low after frame", rcv_clk, 0);
            @(negedge clk);
            line_in = lvl;
            loop_in = lvl;
            loop_en = 1'b0;
            wait_neg(4);
        end

        // Jitter window: spacings 10 and 6, plus a one-sample glitch (R5)
        begin_rx();
        send_cell(~lvl, 4, 4, -1);
        send_cell(1'b1, 4, 6, -1);
        send_cell(1'b0, 4, 4, -1);
        send_cell(1'b0, 2, 4, 1);
        send_cell(1'b1, 4, 4, -1);
        wait_neg(60);
        finish_rx("R5 window and glitch");

        // Timeout and acceptance in the same sample (R7)
        begin
            logic b0;
            b0 = ~lvl;
            begin_rx();
            send_cell(b0, 4, 4, -1);
            send_cell(~b0, 8, 4, -1);
            wait_neg(60);
            finish_rx("R7 gap 12 data");
            check(crs_falls == 1, "R7 gap 12 carrier continuous", crs_falls, 1);
        end
        begin
            logic b0;
            b0 = ~lvl;
            begin_rx();
            send_cell(b0, 4, 4, -1);
            send_cell(~b0, 9, 4, -1);
            wait_neg(60);
            finish_rx("R7 gap 13 data");
            check(crs_falls == 2, "R7 gap 13 carrier dips", crs_falls, 2);
        end

        // Line activity ignored under loopback (R9)
        begin
            int highs;
            @(negedge clk);
            loop_in = lvl;
            line_in = lvl;
            loop_en = 1'b1;
            highs = 0;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (carrier_sense || rcv_clk) highs++;
                line_in = ~line_in;
            end
            wait_neg(4);
            check(highs == 0 && !carrier_sense, "R9 line ignored in loopback", highs, 0);
            @(negedge clk);
            line_in = lvl;
            loop_en = 1'b0;
            wait_neg(4);
        end

        // Reset in the middle of a frame (R1)
        send_cell(~lvl, 4, 4, -1);
        send_cell(1'b1, 4, 4, -1);
        wait_neg(2);
        check(carrier_sense && rcv_data, "R1 frame active before reset", rcv_data, 1);
        @(negedge clk);
        rst     = 1'b1;
        line_in = 1'b0;
        lvl     = 1'b0;
        wait_neg(1);
        check(!carrier_sense && !rcv_clk && !rcv_data, "R1 mid-frame reset clears", rcv_data, 0);
        wait_neg(2);
        rst = 1'b0;
        wait_neg(10);
        check(!carrier_sense, "R1 quiet after reset", carrier_sense, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule